// File: doc/BRIEF.md
# Performance Counter Access Port

This block sits between a software-visible register interface and a bank of performance counters. It does not hold any count. It turns write requests into per-counter write enables with the data already shaped to the counter width. It turns read requests into a selection from the counter values that the bank presents, and it signals a fault for any access that must not take effect.

A write names a bank (general-purpose or fixed), a counter number, an alias and 64 bits of data. The legacy alias keeps only the low 32 bits of the data and sign-extends them. The full-width alias keeps the data as written, but it refuses any value that does not fit the counter. Writes to the fixed bank are always truncated to the fixed width.

A read takes a 32-bit index. The index carries a bank-select bit and a fast-read bit, and its low bits give the counter number. Every access result, whether enable, data, read value or fault, appears on registered outputs one cycle after the request.

Top module: `counter_access_port`

## Requirements
- R1: A general-purpose write with `wr_alias_i`=0 (legacy) ignores data bits 63:32. The stored value is data bit 31 replicated upward over bits 31:0, truncated to GP_W bits, and no fault is raised.
- R2: A general-purpose write with `wr_alias_i`=1 (full width) whose data has no bit set at or above position GP_W stores data[GP_W-1:0].
- R3: A general-purpose full-width write with any data bit set at or above position GP_W pulses `fault_o` and asserts no write enable.
- R4: A write with `wr_bank_i`=1 (fixed bank) stores data[FX_W-1:0] on `fx_wdata_o`. The alias has no effect on it, and data width never causes a fault.
- R5: A write whose counter number is not below the selected bank's counter count pulses `fault_o` and asserts no write enable.
- R6: Each legal write asserts exactly one enable bit for one cycle, the one matching bank and counter number, on the cycle after the request, with the shaped data on that bank's data output.
- R7: A read with index bit 31 clear returns the named counter value, zero-extended to 64 bits, on `rd_data_o` with `rd_valid_o` high one cycle after the request. Index bit 30 picks the fixed bank when set, and bits 29:0 give the counter number.
- R8: A read with index bit 31 set (fast read) returns only the low 32 bits of the counter, with bits 63:32 zero.
- R9: A read whose counter number is not below the selected bank's count (for example index 64) pulses `fault_o`, leaves `rd_valid_o` low and loads zero into `rd_data_o`.
- R10: `fault_o` is high only in the cycle after a faulting request and is low after a cycle with no request.
- R11: While reset is asserted, all enables, `rd_valid_o`, `fault_o` and both data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req_i | input | 1 | Write request strobe |
| wr_alias_i | input | 1 | 0 = legacy 32-bit alias, 1 = full-width alias |
| wr_bank_i | input | 1 | 0 = general-purpose bank, 1 = fixed bank |
| wr_sel_i | input | SEL_W | Counter number for the write |
| wr_data_i | input | 64 | Write data |
| rd_req_i | input | 1 | Read request strobe |
| rd_index_i | input | 32 | Read index: bit 31 fast, bit 30 bank, bits 29:0 number |
| gp_vals_i | input | NUM_GP*GP_W | Current general-purpose counter values, counter 0 in the low bits |
| fx_vals_i | input | NUM_FX*FX_W | Current fixed counter values, counter 0 in the low bits |
| gp_we_o | output | NUM_GP | General-purpose write enables |
| fx_we_o | output | NUM_FX | Fixed write enables |
| gp_wdata_o | output | GP_W | Shaped general-purpose write data |
| fx_wdata_o | output | FX_W | Shaped fixed write data |
| rd_data_o | output | 64 | Read result |
| rd_valid_o | output | 1 | Read result valid |
| fault_o | output | 1 | One-cycle fault pulse |

## Verification
The hardest case to reach is a full-width write whose data fits within 64 bits but leaks a single bit just above the counter width. Uniform random data almost never fits, and cleared data never leaks. The stimulus therefore builds data in three shapes: fully random, masked to the counter width, and masked with one chosen bit at or above the width set. It also mixes legacy writes with bit 31 set and clear. Index stimulus mixes in-range numbers with values just past each bank's count and with large values such as 64. This drives the fault path for both banks and both directions. A read after each write shows through the bank model whether the write reached a counter.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int DATA_W   = 64;
  localparam int INDEX_W  = 32;
  localparam int NUM_W    = 30;
  localparam int FAST_BIT = 31;
  localparam int BANK_BIT = 30;
  localparam int LOW_W    = 32;

  typedef enum logic {
    ALIAS_LEGACY = 1'b0,
    ALIAS_FULL   = 1'b1
  } wr_alias_e;
endpackage

// File: rtl/cap_wr_path.sv
module cap_wr_path
  import cap_pkg::*;
#(
  parameter int NUM_GP = 4,
  parameter int NUM_FX = 3,
  parameter int GP_W   = 48,
  parameter int FX_W   = 48,
  parameter int SEL_W  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_i,
  input  logic                alias_i,
  input  logic                bank_i,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic [DATA_W-1:0]   data_i,
  output logic [NUM_GP-1:0]   gp_we_o,
  output logic [NUM_FX-1:0]   fx_we_o,
  output logic [GP_W-1:0]     gp_wdata_o,
  output logic [FX_W-1:0]     fx_wdata_o,
  output logic                fault_o
);
  localparam logic [SEL_W:0] GP_LIM = (SEL_W+1)'(NUM_GP);
  localparam logic [SEL_W:0] FX_LIM = (SEL_W+1)'(NUM_FX);

  logic              sel_ok, hi_set, fault_nxt, wr_ok;
  logic [GP_W-1:0]   gp_wd_nxt;
  logic [FX_W-1:0]   fx_wd_nxt;
  logic [NUM_GP-1:0] gp_we_nxt, gp_we_q;
  logic [NUM_FX-1:0] fx_we_nxt, fx_we_q;
  logic [GP_W-1:0]   gp_wd_q;
  logic [FX_W-1:0]   fx_wd_q;
  logic              fault_q;

  always_comb begin
    sel_ok    = bank_i ? ({1'b0, sel_i} < FX_LIM) : ({1'b0, sel_i} < GP_LIM);
    hi_set    = |(data_i >> GP_W);
    fault_nxt = req_i & (~sel_ok | (~bank_i & (alias_i == ALIAS_FULL) & hi_set));
    wr_ok     = req_i & ~fault_nxt;
    if (alias_i == ALIAS_FULL) gp_wd_nxt = data_i[GP_W-1:0];
    else                       gp_wd_nxt = {{(GP_W-LOW_W){data_i[LOW_W-1]}}, data_i[LOW_W-1:0]};
    fx_wd_nxt = data_i[FX_W-1:0];
  end

  for (genvar g = 0; g < NUM_GP; g++) begin : g_gp_we
    assign gp_we_nxt[g] = wr_ok & ~bank_i & (sel_i == SEL_W'(g));
  end
  for (genvar f = 0; f < NUM_FX; f++) begin : g_fx_we
    assign fx_we_nxt[f] = wr_ok & bank_i & (sel_i == SEL_W'(f));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gp_we_q <= '0;
      fx_we_q <= '0;
      fault_q <= 1'b0;
    end else begin
      gp_we_q <= gp_we_nxt;
      fx_we_q <= fx_we_nxt;
      fault_q <= fault_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gp_wd_q <= '0;
      fx_wd_q <= '0;
    end else begin
      if (wr_ok & ~bank_i) gp_wd_q <= gp_wd_nxt;
      if (wr_ok &  bank_i) fx_wd_q <= fx_wd_nxt;
    end
  end

  assign gp_we_o    = gp_we_q;
  assign fx_we_o    = fx_we_q;
  assign gp_wdata_o = gp_wd_q;
  assign fx_wdata_o = fx_wd_q;
  assign fault_o    = fault_q;

  AST_WE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gp_we_q, fx_we_q})); // R6
  AST_FAULT_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |-> (gp_we_q == '0) && (fx_we_q == '0)); // R5
  AST_WIDE_FULL_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !bank_i && alias_i && hi_set) |=> fault_q && (gp_we_q == '0)); // R3
  AST_LEGACY_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !bank_i && !alias_i) |=> (fault_q ||
      (&gp_wd_q[GP_W-1:LOW_W-1]) || !(|gp_wd_q[GP_W-1:LOW_W-1]))); // R1
endmodule

// File: rtl/cap_rd_path.sv
module cap_rd_path
  import cap_pkg::*;
#(
  parameter int NUM_GP = 4,
  parameter int NUM_FX = 3,
  parameter int GP_W   = 48,
  parameter int FX_W   = 48
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_i,
  input  logic [INDEX_W-1:0]       index_i,
  input  logic [NUM_GP*GP_W-1:0]   gp_vals_i,
  input  logic [NUM_FX*FX_W-1:0]   fx_vals_i,
  output logic [DATA_W-1:0]        data_o,
  output logic                     valid_o,
  output logic                     fault_o
);
  localparam logic [NUM_W-1:0] GP_LIM = NUM_W'(NUM_GP);
  localparam logic [NUM_W-1:0] FX_LIM = NUM_W'(NUM_FX);

  logic [NUM_W-1:0]  num;
  logic              bank, fast, num_ok;
  logic [DATA_W-1:0] sel_val, data_nxt;
  logic [DATA_W-1:0] data_q;
  logic              valid_q, fault_q;

  always_comb begin
    num     = index_i[NUM_W-1:0];
    bank    = index_i[BANK_BIT];
    fast    = index_i[FAST_BIT];
    num_ok  = bank ? (num < FX_LIM) : (num < GP_LIM);
    sel_val = '0;
    if (bank) begin
      for (int i = 0; i < NUM_FX; i++)
        if (num == NUM_W'(i)) sel_val = DATA_W'(fx_vals_i[i*FX_W +: FX_W]);
    end else begin
      for (int i = 0; i < NUM_GP; i++)
        if (num == NUM_W'(i)) sel_val = DATA_W'(gp_vals_i[i*GP_W +: GP_W]);
    end
    if (!num_ok)   data_nxt = '0;
    else if (fast) data_nxt = {{(DATA_W-LOW_W){1'b0}}, sel_val[LOW_W-1:0]};
    else           data_nxt = sel_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      valid_q <= req_i & num_ok;
      fault_q <= req_i & ~num_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     data_q <= '0;
    else if (req_i) data_q <= data_nxt;
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
  assign fault_o = fault_q;

  AST_RD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_q && fault_q)); // R9
  AST_FAST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && fast) |=> (data_q[DATA_W-1:LOW_W] == '0)); // R8
  AST_BAD_INDEX_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !num_ok) |=> fault_q && !valid_q && (data_q == '0)); // R9
endmodule

// File: rtl/counter_access_port.sv
module counter_access_port
  import cap_pkg::*;
#(
  parameter int NUM_GP = 4,
  parameter int NUM_FX = 3,
  parameter int GP_W   = 48,
  parameter int FX_W   = 48,
  parameter int SEL_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_req_i,
  input  logic                     wr_alias_i,
  input  logic                     wr_bank_i,
  input  logic [SEL_W-1:0]         wr_sel_i,
  input  logic [63:0]              wr_data_i,
  input  logic                     rd_req_i,
  input  logic [31:0]              rd_index_i,
  input  logic [NUM_GP*GP_W-1:0]   gp_vals_i,
  input  logic [NUM_FX*FX_W-1:0]   fx_vals_i,
  output logic [NUM_GP-1:0]        gp_we_o,
  output logic [NUM_FX-1:0]        fx_we_o,
  output logic [GP_W-1:0]          gp_wdata_o,
  output logic [FX_W-1:0]          fx_wdata_o,
  output logic [63:0]              rd_data_o,
  output logic                     rd_valid_o,
  output logic                     fault_o
);
  logic wr_fault, rd_fault;

  cap_wr_path #(
    .NUM_GP(NUM_GP), .NUM_FX(NUM_FX), .GP_W(GP_W), .FX_W(FX_W), .SEL_W(SEL_W)
  ) u_wr (
    .clk(clk), .rst_n(rst_n), .req_i(wr_req_i), .alias_i(wr_alias_i),
    .bank_i(wr_bank_i), .sel_i(wr_sel_i), .data_i(wr_data_i),
    .gp_we_o(gp_we_o), .fx_we_o(fx_we_o), .gp_wdata_o(gp_wdata_o),
    .fx_wdata_o(fx_wdata_o), .fault_o(wr_fault)
  );

  cap_rd_path #(
    .NUM_GP(NUM_GP), .NUM_FX(NUM_FX), .GP_W(GP_W), .FX_W(FX_W)
  ) u_rd (
    .clk(clk), .rst_n(rst_n), .req_i(rd_req_i), .index_i(rd_index_i),
    .gp_vals_i(gp_vals_i), .fx_vals_i(fx_vals_i), .data_o(rd_data_o),
    .valid_o(rd_valid_o), .fault_o(rd_fault)
  );

  assign fault_o = wr_fault | rd_fault;

  AST_FAULT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> $past(wr_req_i || rd_req_i)); // R10
  AST_VALID_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> $past(rd_req_i)); // R7
endmodule

// File: tb/counter_access_port_tb.sv
module counter_access_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_GP = 4;
  localparam int NUM_FX = 3;
  localparam int GP_W   = 48;
  localparam int FX_W   = 48;
  localparam int SEL_W  = 4;
  localparam logic [63:0] GP_MASK = (64'd1 << GP_W) - 64'd1;
  localparam logic [63:0] FX_MASK = (64'd1 << FX_W) - 64'd1;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_req, wr_alias, wr_bank, rd_req;
  logic [SEL_W-1:0] wr_sel;
  logic [63:0] wr_data;
  logic [31:0] rd_index;
  logic [NUM_GP*GP_W-1:0] gp_vals;
  logic [NUM_FX*FX_W-1:0] fx_vals;
  logic [NUM_GP-1:0] gp_we;
  logic [NUM_FX-1:0] fx_we;
  logic [GP_W-1:0] gp_wdata;
  logic [FX_W-1:0] fx_wdata;
  logic [63:0] rd_data;
  logic rd_valid, fault;

  logic [63:0] m_gp [NUM_GP];
  logic [63:0] m_fx [NUM_FX];
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  counter_access_port #(
    .NUM_GP(NUM_GP), .NUM_FX(NUM_FX), .GP_W(GP_W), .FX_W(FX_W), .SEL_W(SEL_W)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_req_i(wr_req), .wr_alias_i(wr_alias),
    .wr_bank_i(wr_bank), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .rd_req_i(rd_req), .rd_index_i(rd_index), .gp_vals_i(gp_vals),
    .fx_vals_i(fx_vals), .gp_we_o(gp_we), .fx_we_o(fx_we),
    .gp_wdata_o(gp_wdata), .fx_wdata_o(fx_wdata), .rd_data_o(rd_data),
    .rd_valid_o(rd_valid), .fault_o(fault)
  );

  // Bench acts as the counter bank, loading on the enables.
  always @(posedge clk) begin
    for (int i = 0; i < NUM_GP; i++)
      if (gp_we[i]) gp_vals[i*GP_W +: GP_W] <= gp_wdata;
    for (int i = 0; i < NUM_FX; i++)
      if (fx_we[i]) fx_vals[i*FX_W +: FX_W] <= fx_wdata;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] shape(input logic al, input logic bk, input logic [63:0] d);
    if (bk) return d & FX_MASK;
    if (al) return d & GP_MASK;
    return {{32{d[31]}}, d[31:0]} & GP_MASK;
  endfunction

  task automatic do_wr(input logic al, input logic bk, input logic [SEL_W-1:0] sel,
                       input logic [63:0] d, input string tag);
    bit legal, flt;
    logic [63:0] ev;
    logic [NUM_GP-1:0] egp;
    logic [NUM_FX-1:0] efx;
    @(negedge clk);
    wr_req = 1; wr_alias = al; wr_bank = bk; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_req = 0;
    legal = bk ? (int'(sel) < NUM_FX) : (int'(sel) < NUM_GP);
    flt = !legal || (!bk && al && ((d >> GP_W) != 0));
    ev = shape(al, bk, d);
    egp = '0; efx = '0;
    if (!flt && !bk) egp[sel] = 1'b1;
    if (!flt &&  bk) efx[sel] = 1'b1;
    chk(fault == flt, tag, 64'(fault), 64'(flt));
    chk(gp_we == egp && fx_we == efx, tag, 64'({gp_we, fx_we}), 64'({egp, efx}));
    if (!flt) begin
      if (bk) begin
        chk(64'(fx_wdata) == ev, tag, 64'(fx_wdata), ev);
        m_fx[sel] = ev;
      end else begin
        chk(64'(gp_wdata) == ev, tag, 64'(gp_wdata), ev);
        m_gp[sel] = ev;
      end
    end
  endtask

  task automatic do_rd(input logic [31:0] idx, input string tag);
    bit legal;
    logic [63:0] ev;
    int n;
    @(negedge clk);
    rd_req = 1; rd_index = idx;
    @(negedge clk);
    rd_req = 0;
    legal = (idx[29:0] < (idx[30] ? NUM_FX : NUM_GP));
    n = int'(idx[29:0]);
    ev = '0;
    if (legal) ev = idx[30] ? m_fx[n] : m_gp[n];
    if (idx[31]) ev = ev & 64'hFFFF_FFFF;
    chk(fault == !legal && rd_valid == legal, tag, 64'({fault, rd_valid}), 64'({!legal, legal}));
    chk(rd_data == ev, tag, rd_data, ev);
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    chk(fault == 1'b0 && rd_valid == 1'b0, tag, 64'({fault, rd_valid}), 64'd0);
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 0; wr_req = 0; wr_alias = 0; wr_bank = 0; wr_sel = '0; wr_data = '0;
    rd_req = 0; rd_index = '0; gp_vals = '0; fx_vals = '0;
    for (int i = 0; i < NUM_GP; i++) m_gp[i] = '0;
    for (int i = 0; i < NUM_FX; i++) m_fx[i] = '0;
    repeat (3) @(negedge clk);
    chk(gp_we == '0 && fx_we == '0 && !rd_valid && !fault && rd_data == '0 &&
        gp_wdata == '0 && fx_wdata == '0, "R11 reset state", 64'({gp_we, fx_we, rd_valid, fault}), 64'd0);
    rst_n = 1;
    idle("R10 idle after reset");

    // Directed corners
    do_wr(1'b0, 1'b0, 4'd0, 64'hFFFF_FF01_2345_6789, "R1 legacy positive");
    do_rd(32'd0, "R7 read gp0");
    do_wr(1'b0, 1'b0, 4'd1, 64'h0000_0000_89AB_CDEF, "R1 legacy negative");
    do_rd(32'd1, "R7 read gp1");
    do_wr(1'b1, 1'b0, 4'd2, 64'hFFFF_FF01_2345_6789, "R3 full too wide");
    do_rd(32'd2, "R3 gp2 untouched");
    do_wr(1'b1, 1'b0, 4'd2, 64'h0001_0000_0000_0000, "R3 bit at width");
    do_wr(1'b1, 1'b0, 4'd2, 64'h0000_FF01_2345_6789, "R2 full fits");
    do_rd(32'd2, "R2 read gp2");
    do_rd(32'h8000_0002, "R8 fast read gp2");
    do_wr(1'b1, 1'b1, 4'd0, 64'hFFFF_FF01_2345_6789, "R4 fixed full wide");
    do_wr(1'b0, 1'b1, 4'd2, 64'hFFFF_FFFF_8000_0001, "R4 fixed legacy");
    do_rd(32'h4000_0000, "R7 read fx0");
    do_rd(32'hC000_0002, "R8 fast read fx2");
    do_wr(1'b0, 1'b0, 4'd4, 64'h1, "R5 gp number past end");
    do_wr(1'b0, 1'b1, 4'd3, 64'h1, "R5 fx number past end");
    do_rd(32'd64, "R9 read index 64");
    idle("R10 idle after fault");
    do_rd(32'h4000_0003, "R9 read fx past end");
    do_rd(32'd4, "R9 read gp past end");

    // Constrained random mix
    for (int it = 0; it < 400; it++) begin
      int kind = int'($urandom_range(0, 9));
      if (kind < 5) begin
        logic [63:0] d = rnd64();
        int shp = int'($urandom_range(0, 2));
        if (shp == 1) d = d & GP_MASK;
        if (shp == 2) d = (d & GP_MASK) | (64'd1 << $urandom_range(GP_W, 63));
        do_wr(1'($urandom()), 1'($urandom()), SEL_W'($urandom_range(0, 5)), d, "R6 random write");
      end else if (kind < 9) begin
        logic [31:0] idx = {1'($urandom()), 1'($urandom()), 30'($urandom_range(0, 4))};
        do_rd(idx, "R7 random read");
      end else begin
        do_rd({2'($urandom()), 30'($urandom_range(5, 1000))}, "R9 random bad read");
        idle("R10 random idle");
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule